// File: doc/BRIEF.md
# Masked Vector Register Arithmetic Unit

This block is a small vector execution engine. It keeps a file of vector registers, each holding 64 elements of a configurable width, plus a bank of 64-bit scalar mask registers. A single command port starts one operation at a time. The operations are: fill a vector register from memory, write a vector register out to memory, add two vector registers element by element, add them only where a mask bit is set, or write a mask register.

Vector operations walk the element index from 0 to 63, one element per cycle. A two-stage pipeline overlaps the register read or memory request of one element with the write-back of the previous element. Because only one data word crosses the memory port per cycle, every vector command occupies the unit for a fixed run of cycles. `busy` covers that run, and `done` marks its end with a one-cycle pulse. Memory is a synchronous single-word port. Read data is expected in the cycle after the read request.

Top module: `vec_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done`, `mem_rd_en` and `mem_wr_en` are all 0.
- R2: Opcode 1 (load) issues exactly 64 reads at addresses base, base+1, …, base+63, one per cycle. The word returned on `mem_rdata` in the cycle after each request becomes element i of register `cmd_vd`.
- R3: Opcode 2 (store) issues exactly 64 writes at addresses base through base+63 in increasing order. Element i of register `cmd_vd` appears on `mem_wdata` with the write to base+i. Reads and writes are never requested in the same cycle.
- R4: Opcode 3 (add) sets element i of `cmd_vd` to element i of `cmd_va` plus element i of `cmd_vb`, modulo 2^ELEM_W, for every i from 0 to 63.
- R5: Opcode 4 (masked add) performs the R4 sum only for indices i where bit i of mask register `cmd_mr` is 1. Every other element of `cmd_vd` keeps its previous value. This includes index 0 and index 63.
- R6: Opcode 5 (mask write) stores the 64-bit `cmd_mval` into mask register `cmd_mr`. `busy` stays low, and `done` is high for exactly the one cycle after the accepting edge.
- R7: A vector command accepted at a clock edge raises `busy` from the next cycle for exactly 66 cycles. `done` is high only in the first cycle after that run, which is one cycle after the last memory beat of a store. Neither memory enable is active while `busy` is low.
- R8: A command presented while `busy` is high is ignored. It causes no memory access, does not change any register, and does not lengthen the running command.
- R9: The destination register may be the same as either source, or both. Each element is computed from the source values it held before the command started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Opcode: 1 load, 2 store, 3 add, 4 masked add, 5 mask write; other values do nothing |
| cmd_vd | input | $clog2(NUM_VREG) | Destination vector register (source for store) |
| cmd_va | input | $clog2(NUM_VREG) | First source vector register |
| cmd_vb | input | $clog2(NUM_VREG) | Second source vector register |
| cmd_mr | input | $clog2(NUM_MREG) | Mask register index |
| cmd_base | input | ADDR_W | Memory base address for load and store |
| cmd_mval | input | VLEN | Value written by a mask write |
| busy | output | 1 | Vector command in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_rd_en | output | 1 | Memory read request |
| mem_wr_en | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | ELEM_W | Memory write data |
| mem_rdata | input | ELEM_W | Memory read data, valid the cycle after a read request |

## Verification
The hardest situation to reach is a write-back that overlaps the read of a register that is also its own destination. With an in-place operation, a pipeline slip would make an element read a value that was just updated, and no single command shows this on its own. The stimulus loads operands that cross the wrap-around boundary, runs an add with destination equal to both sources, and a masked add whose mask sets only the first and last bits. It then stores each result so that every element reaches the memory port. A second hard case is a command arriving mid-run. The bench injects a store during a load and relies on the scoreboard to flag any write that was not expected.

// File: rtl/vec_pkg.sv
package vec_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_STORE = 3'd2,
    OP_ADD   = 3'd3,
    OP_CADD  = 3'd4,
    OP_MSET  = 3'd5
  } vop_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2
  } vstate_e;
endpackage

// File: rtl/vec_regfile.sv
module vec_regfile #(
  parameter int ELEM_W   = 16,
  parameter int NUM_VREG = 4,
  parameter int VLEN     = 64
) (
  input  logic                                   clk,
  input  logic [$clog2(NUM_VREG*VLEN)-1:0]       ra_addr,
  input  logic [$clog2(NUM_VREG*VLEN)-1:0]       rb_addr,
  output logic [ELEM_W-1:0]                      ra_data,
  output logic [ELEM_W-1:0]                      rb_data,
  input  logic                                   we,
  input  logic [$clog2(NUM_VREG*VLEN)-1:0]       wa,
  input  logic [ELEM_W-1:0]                      wd
);
  localparam int DEPTH = NUM_VREG * VLEN;

  logic [ELEM_W-1:0] store_q [DEPTH];

  // one write port, two registered read ports
  always_ff @(posedge clk) begin
    if (we) store_q[wa] <= wd;
    ra_data <= store_q[ra_addr];
    rb_data <= store_q[rb_addr];
  end
endmodule

// File: rtl/vec_mask_bank.sv
module vec_mask_bank #(
  parameter int NUM_MREG = 2,
  parameter int VLEN     = 64
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [$clog2(NUM_MREG)-1:0] wr_sel,
  input  logic [VLEN-1:0]             wr_val,
  input  logic [$clog2(NUM_MREG)-1:0] rd_sel,
  input  logic [$clog2(VLEN)-1:0]     rd_idx,
  output logic                        rd_bit
);
  logic [VLEN-1:0] mreg_q [NUM_MREG];

  for (genvar g = 0; g < NUM_MREG; g++) begin : g_mreg
    always_ff @(posedge clk) begin
      if (rst) mreg_q[g] <= '0;
      else if (wr_en && wr_sel == g) mreg_q[g] <= wr_val;
    end
  end

  assign rd_bit = mreg_q[rd_sel][rd_idx];
endmodule

// File: rtl/vec_lane.sv
module vec_lane import vec_pkg::*; #(
  parameter int ELEM_W = 16
) (
  input  logic              valid,
  input  vop_e              op,
  input  logic              mask_bit,
  input  logic [ELEM_W-1:0] src_a,
  input  logic [ELEM_W-1:0] src_b,
  input  logic [ELEM_W-1:0] load_data,
  output logic              wr_en,
  output logic [ELEM_W-1:0] wr_data
);
  always_comb begin
    wr_en   = 1'b0;
    wr_data = src_a + src_b;
    unique case (op)
      OP_LOAD: begin
        wr_en   = valid;
        wr_data = load_data;
      end
      OP_ADD:  wr_en = valid;
      OP_CADD: wr_en = valid && mask_bit;
      default: wr_en = 1'b0;
    endcase
  end
endmodule

// File: rtl/vec_unit.sv
module vec_unit import vec_pkg::*; #(
  parameter int ELEM_W   = 16,
  parameter int VLEN     = 64,
  parameter int NUM_VREG = 4,
  parameter int NUM_MREG = 2,
  parameter int ADDR_W   = 10
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cmd_valid,
  input  logic [2:0]                  cmd_op,
  input  logic [$clog2(NUM_VREG)-1:0] cmd_vd,
  input  logic [$clog2(NUM_VREG)-1:0] cmd_va,
  input  logic [$clog2(NUM_VREG)-1:0] cmd_vb,
  input  logic [$clog2(NUM_MREG)-1:0] cmd_mr,
  input  logic [ADDR_W-1:0]           cmd_base,
  input  logic [VLEN-1:0]             cmd_mval,
  output logic                        busy,
  output logic                        done,
  output logic                        mem_rd_en,
  output logic                        mem_wr_en,
  output logic [ADDR_W-1:0]           mem_addr,
  output logic [ELEM_W-1:0]           mem_wdata,
  input  logic [ELEM_W-1:0]           mem_rdata
);
  localparam int IDX_W = $clog2(VLEN);
  localparam int VR_W  = $clog2(NUM_VREG);
  localparam int MR_W  = $clog2(NUM_MREG);
  localparam int RF_AW = $clog2(NUM_VREG * VLEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(VLEN - 1);

  vop_e             cmd_kind;
  logic             is_vec_cmd;
  logic             accept;
  logic             mset_we;

  vstate_e          st_q;
  vop_e             op_q;
  logic [VR_W-1:0]  vd_q, va_q, vb_q;
  logic [MR_W-1:0]  mr_q;
  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0] cnt_q;
  logic             busy_q, done_q;

  // stage 0: request / register read, stage 1: write-back / store beat
  logic             s0_v, s1_v;
  logic [IDX_W-1:0] s0_idx, s1_idx;
  logic [ADDR_W-1:0] s0_addr, s1_addr;
  logic             s1_mbit;

  logic             mask_bit;
  logic [ELEM_W-1:0] ra_data, rb_data;
  logic             wb_en;
  logic [ELEM_W-1:0] wb_data;
  logic [VR_W-1:0]  rsel_a;

  assign cmd_kind   = vop_e'(cmd_op);
  assign is_vec_cmd = (cmd_kind == OP_LOAD) || (cmd_kind == OP_STORE) ||
                      (cmd_kind == OP_ADD)  || (cmd_kind == OP_CADD);
  assign accept     = cmd_valid && (st_q == ST_IDLE) && is_vec_cmd;
  assign mset_we    = cmd_valid && (st_q == ST_IDLE) && (cmd_kind == OP_MSET);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      s0_v   <= 1'b0;
      s1_v   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      s0_v   <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            st_q   <= ST_ISSUE;
            busy_q <= 1'b1;
            cnt_q  <= '0;
          end else if (mset_we) begin
            done_q <= 1'b1;
          end
        end
        ST_ISSUE: begin
          s0_v  <= 1'b1;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_IDX) st_q <= ST_DRAIN;
        end
        ST_DRAIN: begin
          if (s1_v && s1_idx == LAST_IDX) begin
            st_q   <= ST_IDLE;
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
      s1_v <= s0_v;
    end
  end

  // command fields and pipeline payload: no reset needed
  always_ff @(posedge clk) begin
    if (accept) begin
      op_q   <= cmd_kind;
      vd_q   <= cmd_vd;
      va_q   <= cmd_va;
      vb_q   <= cmd_vb;
      mr_q   <= cmd_mr;
      base_q <= cmd_base;
    end
    s0_idx  <= cnt_q;
    s0_addr <= base_q + ADDR_W'(cnt_q);
    s1_idx  <= s0_idx;
    s1_addr <= s0_addr;
    s1_mbit <= mask_bit;
  end

  assign rsel_a = (op_q == OP_STORE) ? vd_q : va_q;

  vec_mask_bank #(.NUM_MREG(NUM_MREG), .VLEN(VLEN)) i_mask (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (mset_we),
    .wr_sel (cmd_mr),
    .wr_val (cmd_mval),
    .rd_sel (mr_q),
    .rd_idx (s0_idx),
    .rd_bit (mask_bit)
  );

  vec_regfile #(.ELEM_W(ELEM_W), .NUM_VREG(NUM_VREG), .VLEN(VLEN)) i_rf (
    .clk     (clk),
    .ra_addr (RF_AW'({rsel_a, s0_idx})),
    .rb_addr (RF_AW'({vb_q, s0_idx})),
    .ra_data (ra_data),
    .rb_data (rb_data),
    .we      (wb_en),
    .wa      (RF_AW'({vd_q, s1_idx})),
    .wd      (wb_data)
  );

  vec_lane #(.ELEM_W(ELEM_W)) i_lane (
    .valid     (s1_v),
    .op        (op_q),
    .mask_bit  (s1_mbit),
    .src_a     (ra_data),
    .src_b     (rb_data),
    .load_data (mem_rdata),
    .wr_en     (wb_en),
    .wr_data   (wb_data)
  );

  assign busy      = busy_q;
  assign done      = done_q;
  assign mem_rd_en = s0_v && (op_q == OP_LOAD);
  assign mem_wr_en = s1_v && (op_q == OP_STORE);
  assign mem_addr  = (op_q == OP_STORE) ? s1_addr : s0_addr;
  assign mem_wdata = ra_data;
endmodule

// File: rtl/vec_unit_chk.sv
module vec_unit_chk #(
  parameter int VLEN   = 64,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              mem_rd_en,
  input logic              mem_wr_en,
  input logic [ADDR_W-1:0] mem_addr
);
  int unsigned run_len;

  always_ff @(posedge clk) begin
    if (rst || !busy) run_len <= 0;
    else run_len <= run_len + 1;
  end

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && mem_wr_en)); // R3

  AST_LOAD_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1))); // R2

  AST_STORE_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_en && $past(mem_wr_en)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1))); // R3

  AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_rd_en && !mem_wr_en)); // R7

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done); // R7

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_len < VLEN + 2)); // R7
endmodule

bind vec_unit vec_unit_chk #(.VLEN(VLEN), .ADDR_W(ADDR_W)) i_vec_unit_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .mem_rd_en (mem_rd_en),
  .mem_wr_en (mem_wr_en),
  .mem_addr  (mem_addr)
);

// File: tb/test_vec_unit.sv
module test_vec_unit;
  localparam int CLK_P  = 10;
  localparam int EW     = 16;
  localparam int VL     = 64;
  localparam int NVR    = 4;
  localparam int NMR    = 2;
  localparam int AW     = 10;
  localparam int RUNLEN = 66;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [1:0] cmd_vd = '0, cmd_va = '0, cmd_vb = '0;
  logic [0:0] cmd_mr = '0;
  logic [AW-1:0] cmd_base = '0;
  logic [VL-1:0] cmd_mval = '0;
  logic busy, done, mem_rd_en, mem_wr_en;
  logic [AW-1:0] mem_addr;
  logic [EW-1:0] mem_wdata;
  logic [EW-1:0] mem_rdata = '0;

  always #(CLK_P/2) clk = ~clk;

  vec_unit #(.ELEM_W(EW), .VLEN(VL), .NUM_VREG(NVR), .NUM_MREG(NMR), .ADDR_W(AW)) i_vec_unit (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_vd(cmd_vd), .cmd_va(cmd_va), .cmd_vb(cmd_vb), .cmd_mr(cmd_mr),
    .cmd_base(cmd_base), .cmd_mval(cmd_mval), .busy(busy), .done(done),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory model: synchronous read, data one cycle after request
  logic [EW-1:0] mem [1 << AW];
  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
    if (mem_wr_en) mem[mem_addr] <= mem_wdata;
  end

  // reference state built from the requirements
  logic [EW-1:0] vm [NVR][VL];
  logic [VL-1:0] mm [NMR];

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    logic [AW-1:0] a;
    logic [EW-1:0] d;
    string         tag;
  } exp_t;
  exp_t sbq[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor: every write must match the next expected item
  always @(negedge clk) begin
    if (!rst && mem_wr_en) begin
      if (sbq.size() == 0) begin
        n_chk++;
        n_fail++;
        $display("FAIL R8 unexpected write actual=%0h expected=none", mem_addr);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(mem_addr == e.a, e.tag, "store address", mem_addr, e.a);
        chk(mem_wdata == e.d, e.tag, "store data", mem_wdata, e.d);
      end
    end
  end

  task automatic issue(input logic [2:0] op, input logic [1:0] vd, input logic [1:0] va,
                       input logic [1:0] vb, input logic [0:0] mr,
                       input logic [AW-1:0] base, input logic [VL-1:0] mval);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_vd = vd; cmd_va = va; cmd_vb = vb;
    cmd_mr = mr; cmd_base = base; cmd_mval = mval;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_vec(input string tag, input bit check_len);
    int cnt = 0;
    while (busy) begin
      cnt++;
      @(negedge clk);
    end
    chk(done == 1'b1, tag, "done after busy falls", done, 1);
    if (check_len) chk(cnt == RUNLEN, "R7", "busy length", cnt, RUNLEN);
    @(negedge clk);
    chk(done == 1'b0, "R7", "done is one cycle", done, 0);
  endtask

  task automatic do_load(input logic [1:0] vd, input logic [AW-1:0] base);
    for (int i = 0; i < VL; i++) vm[vd][i] = mem[AW'(base + i)];
    issue(3'd1, vd, 2'd0, 2'd0, 1'b0, base, '0);
    wait_vec("R2", 1'b1);
  endtask

  task automatic do_store(input logic [1:0] vr, input logic [AW-1:0] base, input string tag);
    for (int i = 0; i < VL; i++) begin
      exp_t e;
      e.a = AW'(base + i); e.d = vm[vr][i]; e.tag = tag;
      sbq.push_back(e);
    end
    issue(3'd2, vr, 2'd0, 2'd0, 1'b0, base, '0);
    wait_vec(tag, 1'b1);
    chk(sbq.size() == 0, tag, "all stores seen", sbq.size(), 0);
  endtask

  task automatic do_add(input bit masked, input logic [1:0] vd, input logic [1:0] va,
                        input logic [1:0] vb, input logic [0:0] mr);
    logic [EW-1:0] a_c [VL];
    logic [EW-1:0] b_c [VL];
    for (int i = 0; i < VL; i++) begin a_c[i] = vm[va][i]; b_c[i] = vm[vb][i]; end
    for (int i = 0; i < VL; i++)
      if (!masked || mm[mr][i]) vm[vd][i] = a_c[i] + b_c[i];
    issue(masked ? 3'd4 : 3'd3, vd, va, vb, mr, '0, '0);
    wait_vec(masked ? "R5" : "R4", 1'b1);
  endtask

  task automatic do_mset(input logic [0:0] mr, input logic [VL-1:0] val);
    mm[mr] = val;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd5; cmd_mr = mr; cmd_mval = val;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b0, "R6", "busy stays low", busy, 0);
    chk(done == 1'b1, "R6", "done pulse", done, 1);
    @(negedge clk);
    chk(done == 1'b0, "R6", "done single cycle", done, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = EW'(16'hDEAD ^ i);
    for (int i = 0; i < VL; i++) begin
      mem[i]       = EW'(i * 3 + 1);
      mem[100 + i] = EW'(16'hFFF0 + i);
      mem[200 + i] = EW'(16'h5000 + i * 7);
    end
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1", "status in reset", {busy, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1", "status after reset", {busy, done}, 0);
    chk(mem_rd_en == 1'b0 && mem_wr_en == 1'b0, "R1", "memory idle", {mem_rd_en, mem_wr_en}, 0);

    do_load(2'd0, 10'd0);          // R2
    do_load(2'd1, 10'd100);        // R2, values near wrap
    do_store(2'd0, 10'd300, "R3"); // R3 load/store round trip
    do_add(1'b0, 2'd2, 2'd0, 2'd1, 1'b0);  // R4 with wrap-around
    do_store(2'd2, 10'd400, "R4");

    do_mset(1'b0, 64'hAAAA_AAAA_AAAA_AAAA);  // R6
    do_load(2'd3, 10'd200);
    do_add(1'b1, 2'd3, 2'd0, 2'd1, 1'b0);    // R5 alternate elements
    do_store(2'd3, 10'd500, "R5");
    do_mset(1'b1, 64'h8000_0000_0000_0001);  // R6
    do_add(1'b1, 2'd3, 2'd1, 2'd1, 1'b1);    // R5 first and last only
    do_store(2'd3, 10'd600, "R5");

    do_add(1'b0, 2'd1, 2'd1, 2'd1, 1'b0);    // R9 destination equals both sources
    do_store(2'd1, 10'd700, "R9");

    // R8: a store presented mid-load must be dropped
    for (int i = 0; i < VL; i++) vm[0][i] = mem[200 + i];
    issue(3'd1, 2'd0, 2'd0, 2'd0, 1'b0, 10'd200, '0);
    repeat (4) @(negedge clk);
    issue(3'd2, 2'd2, 2'd0, 2'd0, 1'b0, 10'd800, '0);
    issue(3'd3, 2'd0, 2'd2, 2'd2, 1'b0, 10'd0, '0);
    wait_vec("R8", 1'b0);
    chk(sbq.size() == 0, "R8", "no stray writes queued", sbq.size(), 0);
    chk(mem[800] == EW'(16'hDEAD ^ 800), "R8", "ignored store left memory", mem[800], 16'hDEAD ^ 800);
    do_store(2'd0, 10'd900, "R8");

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule